// File: doc/BRIEF.md
# Memory-Mapped Store Router

This block sits between a minimal processor-side bus and the things that bus can reach. Each cycle the bus may present a 16-bit address together with a byte of write data, a write strobe and a read request. The router turns the address into one select line out of four: a 256-byte RAM window, an LED output register, a command/status register, or "nothing here". Stores are steered to the selected target. Loads come back through a registered read multiplexer one cycle later. The processor side never learns which target took a store.

The RAM window at 0x2000 to 0x20FF is plain storage. The LED register at 0x0040 holds one bit, and that bit drives the `led_out` pin directly. The command register at 0xF000 keeps nothing that is written to it. A store there raises `cmd_pulse` for one cycle and sets a sticky "command seen" flag. A load from 0xF000 returns that flag as a status word. So at this address, reading back what was written does not give the written byte. Any other address reads as zero, and stores to it are lost. Reset is synchronous and active low. It clears the device state and the read register but leaves the RAM contents alone.

Top module: `mmr_router`

## Requirements
- R1: For every 16-bit address, exactly one of the four target selects (RAM, LED, command, none) is active.
- R2: A byte stored to any address 0x2000–0x20FF is returned exactly by a later load of the same address.
- R3: A store to 0x0040 loads write-data bit 0 into `led_out` at the clock edge that takes the store. A load of 0x0040 returns the LED bit in bit 0, with all other bits zero.
- R4: A store to any address other than 0x0040 leaves `led_out` unchanged.
- R5: A store to 0xF000 changes no RAM byte. It drives `cmd_pulse` high for exactly the one cycle that follows the store edge, and back-to-back stores keep it high for one cycle per store.
- R6: A load of 0xF000 returns 0x01 if at least one command store has happened since reset, and 0x00 otherwise, whatever data was stored.
- R7: A load of an address outside the three mapped regions returns 0x00. A store to such an address changes no RAM byte and no device state.
- R8: `bus_rdata` is registered. It shows the loaded value in the cycle after `bus_re` is sampled high, and it holds its value while `bus_re` is low.
- R9: While `rst_n` is low at a clock edge, `led_out`, `cmd_pulse`, the status flag and `bus_rdata` are cleared to zero. RAM contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Store data |
| bus_we | input | 1 | Store strobe, one cycle per store |
| bus_re | input | 1 | Load request |
| bus_rdata | output | 8 | Registered load data |
| led_out | output | 1 | LED drive bit |
| cmd_pulse | output | 1 | One-cycle side-effect pulse per command store |

## Verification
The assertions assume that the bus never raises `bus_we` and `bus_re` in the same cycle. When it does, the RAM read returns the byte held before the store, and the properties make no claim about that case. The assertions also assume that reset is held low from the very first clock edge. The bench respects both assumptions. Its store and load tasks each drive exactly one strobe for one cycle, and all inputs change on the falling edge. Reset is asserted from time zero and again in the middle of the run.

// File: rtl/mmr_pkg.sv
// Package: shared target encoding for the store router.
// Assumes: the four targets are indexed 0..3 in the one-hot select vector.
package mmr_pkg;
    typedef enum logic [1:0] {
        TGT_RAM  = 2'd0,
        TGT_LED  = 2'd1,
        TGT_CMD  = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    localparam int NTGT = 4;
endpackage

// File: rtl/mmr_decode.sv
// Module: mmr_decode
// Maps a bus address onto a one-hot target select. Addresses that fall in
// none of the regions select TGT_NONE.
// Assumes: RAM_BASE is aligned to the RAM window size (2**RAM_AW).
module mmr_decode
    import mmr_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          RAM_AW   = 8,
    parameter logic [15:0] RAM_BASE = 16'h2000,
    parameter logic [15:0] LED_ADDR = 16'h0040,
    parameter logic [15:0] CMD_ADDR = 16'hF000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NTGT-1:0]   sel
);
    localparam int HI_W = ADDR_W - RAM_AW;

    logic [HI_W-1:0] ram_page;
    assign ram_page = RAM_BASE[ADDR_W-1:RAM_AW];

    // Priority chain: exactly one select bit is set on every path.
    always_comb begin
        sel = '0;
        if (addr[ADDR_W-1:RAM_AW] == ram_page)
            sel[int'(TGT_RAM)] = 1'b1;
        else if (addr == LED_ADDR[ADDR_W-1:0])
            sel[int'(TGT_LED)] = 1'b1;
        else if (addr == CMD_ADDR[ADDR_W-1:0])
            sel[int'(TGT_CMD)] = 1'b1;
        else
            sel[int'(TGT_NONE)] = 1'b1;
    end
endmodule

// File: rtl/mmr_ram.sv
// Module: mmr_ram
// Byte RAM with a synchronous write and an asynchronous read port. The
// caller registers the read result.
// Assumes: the contents have no reset, and start undefined.
module mmr_ram #(
    parameter int DATA_W = 8,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store path: write the addressed byte when strobed.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/mmr_devregs.sv
// Module: mmr_devregs
// Holds the device-side state: the LED bit, the one-cycle command pulse and
// the sticky "command seen" status flag.
// Assumes: led_we and cmd_we are never high together (they come from a
// one-hot decode).
module mmr_devregs (
    input  logic clk,
    input  logic rst_n,
    input  logic led_we,
    input  logic cmd_we,
    input  logic led_d,
    output logic led_q,
    output logic pulse_q,
    output logic seen_q
);
    // Device state update, cleared by synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_q   <= 1'b0;
            pulse_q <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            if (led_we)
                led_q <= led_d;
            pulse_q <= cmd_we;
            if (cmd_we)
                seen_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mmr_router.sv
// Module: mmr_router (top)
// Decodes each bus cycle onto RAM, the LED register or the command/status
// register, gates the store strobe to the selected target, and registers
// the read data from the selected target.
// Assumes: bus_we and bus_re are not asserted in the same cycle.
module mmr_router
    import mmr_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          RAM_AW   = 8,
    parameter logic [15:0] RAM_BASE = 16'h2000,
    parameter logic [15:0] LED_ADDR = 16'h0040,
    parameter logic [15:0] CMD_ADDR = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              led_out,
    output logic              cmd_pulse
);
    logic [NTGT-1:0]   sel;
    logic [DATA_W-1:0] ram_rd;
    logic              seen;
    logic [DATA_W-1:0] rd_mux;

    mmr_decode #(
        .ADDR_W  (ADDR_W),
        .RAM_AW  (RAM_AW),
        .RAM_BASE(RAM_BASE),
        .LED_ADDR(LED_ADDR),
        .CMD_ADDR(CMD_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .sel (sel)
    );

    mmr_ram #(
        .DATA_W(DATA_W),
        .AW    (RAM_AW)
    ) u_ram (
        .clk  (clk),
        .we   (bus_we & sel[int'(TGT_RAM)]),
        .addr (bus_addr[RAM_AW-1:0]),
        .wdata(bus_wdata),
        .rdata(ram_rd)
    );

    mmr_devregs u_dev (
        .clk    (clk),
        .rst_n  (rst_n),
        .led_we (bus_we & sel[int'(TGT_LED)]),
        .cmd_we (bus_we & sel[int'(TGT_CMD)]),
        .led_d  (bus_wdata[0]),
        .led_q  (led_out),
        .pulse_q(cmd_pulse),
        .seen_q (seen)
    );

    // Read multiplexer: pick the selected target's read value, zero if unmapped.
    always_comb begin
        rd_mux = '0;
        unique case (1'b1)
            sel[int'(TGT_RAM)]: rd_mux = ram_rd;
            sel[int'(TGT_LED)]: rd_mux = {{(DATA_W-1){1'b0}}, led_out};
            sel[int'(TGT_CMD)]: rd_mux = {{(DATA_W-1){1'b0}}, seen};
            default:            rd_mux = '0;
        endcase
    end

    // Read data register: load on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_re)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/mmr_router_chk.sv
// Module: mmr_router_chk
// Checker bound to mmr_router. It observes the ports and the internal select
// vector and checks the decode, device and read-path rules over time.
// Assumes: bus_we and bus_re are never high together, and reset is low at
// the first edge.
module mmr_router_chk #(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          RAM_AW   = 8,
    parameter logic [15:0] RAM_BASE = 16'h2000,
    parameter logic [15:0] LED_ADDR = 16'h0040,
    parameter logic [15:0] CMD_ADDR = 16'hF000
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              led_out,
    input logic              cmd_pulse,
    input logic [3:0]        sel
);
    logic is_led, is_cmd, is_ram, is_none;
    assign is_led  = (bus_addr == LED_ADDR[ADDR_W-1:0]);
    assign is_cmd  = (bus_addr == CMD_ADDR[ADDR_W-1:0]);
    assign is_ram  = (bus_addr >= RAM_BASE[ADDR_W-1:0]) &&
                     (bus_addr <= RAM_BASE[ADDR_W-1:0] + ADDR_W'((1 << RAM_AW) - 1));
    assign is_none = !is_led && !is_cmd && !is_ram;

    // R1: exactly one select line per cycle
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);

    // R3: an LED store loads bit 0
    p_led_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && is_led) |=> (led_out == $past(bus_wdata[0])));

    // R4: the LED holds unless stored
    p_led_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && is_led) |=> $stable(led_out));

    // R5: a pulse follows every command store
    p_pulse_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && is_cmd) |=> cmd_pulse);

    // R5: no pulse without a command store
    p_pulse_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && is_cmd) |=> !cmd_pulse);

    // R6: the status word has only bit 0 live
    p_status_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && is_cmd) |=> (bus_rdata[DATA_W-1:1] == '0));

    // R7: unmapped loads return zero
    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && is_none) |=> (bus_rdata == '0));

    // R8: read data holds without a request
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

    // R9: reset clears the device outputs and the read register
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!led_out && !cmd_pulse && bus_rdata == '0));
endmodule

bind mmr_router mmr_router_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RAM_AW  (RAM_AW),
    .RAM_BASE(RAM_BASE),
    .LED_ADDR(LED_ADDR),
    .CMD_ADDR(CMD_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .led_out  (led_out),
    .cmd_pulse(cmd_pulse),
    .sel      (sel)
);

// File: tb/mmr_router_tb.sv
// Bench for mmr_router. It sweeps the RAM window and samples the whole
// address space, comparing every output with a model built from the
// requirements.
module mmr_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic        led_out;
    logic        cmd_pulse;

    int checks = 0;
    int bad = 0;

    logic [7:0] ram_m [256];
    logic       led_m = 1'b0;
    logic       seen_m = 1'b0;

    always #10 clk = ~clk;

    mmr_router u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .led_out(led_out), .cmd_pulse(cmd_pulse)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Store: one cycle with bus_we high. Returns at the falling edge after the store edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; bus_re = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
        if (a >= 16'h2000 && a <= 16'h20FF) ram_m[a[7:0]] = d;
        else if (a == 16'h0040) led_m = d[0];
        else if (a == 16'hF000) seen_m = 1'b1;
    endtask

    // Load: one cycle with bus_re high. Returns the registered data.
    task automatic rd(input logic [15:0] a, output logic [7:0] q);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1; bus_we = 1'b0;
        @(negedge clk);
        bus_re = 1'b0;
        q = bus_rdata;
    endtask

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        if (a >= 16'h2000 && a <= 16'h20FF) return ram_m[a[7:0]];
        if (a == 16'h0040) return {7'b0, led_m};
        if (a == 16'hF000) return {7'b0, seen_m};
        return 8'h00;
    endfunction

    function automatic string req_of(input logic [15:0] a);
        if (a >= 16'h2000 && a <= 16'h20FF) return "R2";
        if (a == 16'h0040) return "R3";
        if (a == 16'hF000) return "R6";
        return "R7";
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        logic [7:0] q;
        logic [7:0] held;
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", led_out, 0);
        chk("R9", cmd_pulse, 0);
        chk("R9", bus_rdata, 0);
        rst_n = 1'b1;

        // R2: fill the whole RAM window, then read it back
        for (int i = 0; i < 256; i++) wr(16'h2000 + 16'(i), 8'((i * 37 + 11) & 255));
        for (int i = 0; i < 256; i++) begin
            rd(16'h2000 + 16'(i), q);
            chk("R2", q, exp_read(16'h2000 + 16'(i)));
        end

        // R3 / R6: device reads before any device store
        rd(16'h0040, q); chk("R3", q, 0);
        rd(16'hF000, q); chk("R6", q, 0);

        // R3: LED follows bit 0 of the stored byte
        wr(16'h0040, 8'h41); chk("R3", led_out, 1);
        rd(16'h0040, q);     chk("R3", q, 8'h01);
        wr(16'h0040, 8'hFE); chk("R3", led_out, 0);
        wr(16'h0040, 8'h01); chk("R3", led_out, 1);

        // R4: stores elsewhere do not touch the LED
        wr(16'h2005, 8'h00); chk("R4", led_out, 1);
        wr(16'h0041, 8'h00); chk("R4", led_out, 1);
        wr(16'h003F, 8'h00); chk("R4", led_out, 1);
        wr(16'hF001, 8'h00); chk("R4", led_out, 1);
        wr(16'h1234, 8'h00); chk("R4", led_out, 1);

        // R5: a command store gives a single pulse and stores nothing
        chk("R5", cmd_pulse, 0);
        wr(16'hF000, 8'hAA); chk("R5", cmd_pulse, 1);
        @(negedge clk);      chk("R5", cmd_pulse, 0);
        rd(16'hF000, q);     chk("R6", q, 8'h01);
        chk("R4", led_out, 1);
        wr(16'hF000, 8'h00);
        rd(16'hF000, q);     chk("R6", q, 8'h01);
        for (int i = 0; i < 256; i += 17) begin
            rd(16'h2000 + 16'(i), q);
            chk("R5", q, exp_read(16'h2000 + 16'(i)));
        end

        // R5: back-to-back command stores, one pulse cycle each
        @(negedge clk);
        bus_addr = 16'hF000; bus_wdata = 8'h55; bus_we = 1'b1;
        @(negedge clk); chk("R5", cmd_pulse, 1);
        @(negedge clk); chk("R5", cmd_pulse, 1);
        bus_we = 1'b0;
        @(negedge clk); chk("R5", cmd_pulse, 0);

        // R7: stores to unmapped addresses change no RAM byte
        wr(16'h2100, 8'h99); wr(16'h1FFF, 8'h99); wr(16'h3000, 8'h99);
        wr(16'h0000, 8'h99); wr(16'hFFFF, 8'h99);
        for (int i = 0; i < 256; i++) begin
            rd(16'h2000 + 16'(i), q);
            chk("R7", q, exp_read(16'h2000 + 16'(i)));
        end
        chk("R7", led_out, 1);

        // R1 / R7: sample the address space, plus the region edges
        for (int a = 0; a < 65536; a += 97) begin
            rd(16'(a), q);
            chk(req_of(16'(a)), q, exp_read(16'(a)));
        end
        foreach (ram_m[i]) begin end
        begin
            logic [15:0] edges [10] = '{16'h0000, 16'h003F, 16'h0040, 16'h0041,
                16'h1FFF, 16'h2000, 16'h20FF, 16'h2100, 16'hF000, 16'hFFFF};
            foreach (edges[k]) begin
                rd(edges[k], q);
                chk("R1", q, exp_read(edges[k]));
            end
        end

        // R8: rdata holds while bus_re is low, even as the address moves
        rd(16'h20FF, q);
        held = q;
        @(negedge clk); bus_addr = 16'h0040; chk("R8", bus_rdata, held);
        @(negedge clk); bus_addr = 16'hF000; chk("R8", bus_rdata, held);
        wr(16'h20FF, 8'h3C);                 chk("R8", bus_rdata, held);

        // R9: mid-run reset clears device state but keeps RAM
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R9", led_out, 0);
        chk("R9", bus_rdata, 0);
        chk("R9", cmd_pulse, 0);
        rst_n = 1'b1;
        led_m = 1'b0; seen_m = 1'b0;
        rd(16'hF000, q); chk("R9", q, 0);
        rd(16'h0040, q); chk("R9", q, 0);
        rd(16'h2010, q); chk("R9", q, exp_read(16'h2010));
        rd(16'h20FF, q); chk("R9", q, 8'h3C);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule